// File: doc/BRIEF.md
# Ballast Supply Mode Sequencer

This block is the supply-state controller of a lamp ballast driver that takes its switching commands from a microcontroller. It watches digital flags from external supply and reference comparators, plus the low-side and high-side half-bridge command inputs. From these it decides which of four supply states the chip is in: start-up, save, running or shut-down. For each state it drives enables for the high-voltage start-up current source, the 5 V reference and its current capability, the clamp sink that holds the reference pin low, the supply regulator, the over-current protection and the gate drivers.

All flags and commands are asynchronous to the block clock and pass through two-flop synchronizers first. Edges on the command inputs are found after the synchronizers. Two timings are counted in clock cycles and set by parameters: the minimum dwell in save before the drivers may be enabled, and the length of silence on the low-side command that drops the block back from running to save. The current state is exported as a 2-bit code.

Top module: `ballast_mode_seq`

## Requirements
- R1: After reset the block is in start-up. The state code on `mode` is 0 for start-up, 1 for save, 2 for running and 3 for shut-down.
- R2: In start-up `hv_src_en` and `ref_clamp_en` are 1. `ref_en`, `ref_hi_cur`, `reg_en`, `ocp_en` and `drv_en` are 0.
- R3: From start-up the block moves to save once `vcc_above_on` is seen high and `vcc_below_refoff` is low.
- R4: In save `ref_en` is 1 and `ref_hi_cur` is 0. `ref_clamp_en`, `reg_en`, `ocp_en` and `drv_en` are 0.
- R5: In save `hv_src_en` turns on when `vcc_below_save` is high and turns off when `vcc_above_on` is high. With both flags low it keeps its last value. It is 0 on entry to save from start-up or shut-down.
- R6: Save moves to running only on a falling edge of `hs_cmd`, only while `ref_above_en` is high, and only after at least DWELL_US times CLK_MHZ cycles in save. A rising edge of `hs_cmd` never causes the move.
- R7: From save or shut-down, `vcc_below_refoff` high sends the block to start-up. This check takes priority over every other exit from those states.
- R8: In running `hv_src_en` and `ref_clamp_en` are 0. `ref_en`, `ref_hi_cur`, `reg_en`, `ocp_en` and `drv_en` are 1.
- R9: In running, every edge of `ls_cmd` restarts an inactivity count. When IDLE_US times CLK_MHZ cycles pass without an edge, the block returns to save.
- R10: Running moves to shut-down when `vcc_below_off` or `ref_below_fault` is high. This takes priority over the inactivity exit.
- R11: In shut-down `hv_src_en` and `ref_en` are 1. `ref_hi_cur`, `ref_clamp_en`, `reg_en`, `ocp_en` and `drv_en` are 0. The block moves to save once `vcc_above_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Supply is above the turn-on level |
| vcc_below_save | input | 1 | Supply is below the save-mode restart level |
| vcc_below_off | input | 1 | Supply is below the turn-off level |
| vcc_below_refoff | input | 1 | Supply is below the reference-off level |
| ref_above_en | input | 1 | Reference is above the driver-enable level |
| ref_below_fault | input | 1 | Reference is below its fault level |
| ls_cmd | input | 1 | Low-side gate command from the microcontroller |
| hs_cmd | input | 1 | High-side gate command from the microcontroller |
| hv_src_en | output | 1 | High-voltage start-up source enable |
| ref_en | output | 1 | Reference output enable |
| ref_hi_cur | output | 1 | Reference high-current mode |
| ref_clamp_en | output | 1 | Reference pin clamp sink enable |
| reg_en | output | 1 | Supply regulator enable |
| ocp_en | output | 1 | Over-current protection enable |
| drv_en | output | 1 | Gate driver enable |
| mode | output | 2 | Encoded current state |

## Verification
The bound checker checks these on every cycle:
- the output pattern of each state;
- that the drivers are enabled only in running;
- that running is entered only from save, on a synchronized high-side falling edge with a healthy reference and after the dwell, which the checker counts itself;
- that shut-down is entered only from running;
- that a drop from running to save never happens in a cycle with a low-side edge;
- that a reference-off flag in save forces start-up.

The hysteresis of the start-up source, the exact dwell and inactivity windows, the restart of the inactivity count by low-side edges, and the return paths from shut-down depend on input history. Only the bench's directed and random scenarios can show those.

// File: rtl/bms_pkg.sv
`timescale 1ns/1ps
package bms_pkg;
    typedef enum logic [1:0] {
        ST_STARTUP = 2'd0,
        ST_SAVE    = 2'd1,
        ST_RUN     = 2'd2,
        ST_SHDN    = 2'd3
    } bms_mode_e;
endpackage

// File: rtl/bms_sync.sv
`timescale 1ns/1ps
// Multi-bit two-stage synchronizer for independent level flags.
module bms_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bms_hist.sv
`timescale 1ns/1ps
// One-cycle history register used for edge detection on synchronized inputs.
module bms_hist #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ballast_mode_seq.sv
`timescale 1ns/1ps
module ballast_mode_seq
    import bms_pkg::*;
#(
    parameter int CLK_MHZ  = 200,
    parameter int DWELL_US = 10,
    parameter int IDLE_US  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_on,
    input  logic       vcc_below_save,
    input  logic       vcc_below_off,
    input  logic       vcc_below_refoff,
    input  logic       ref_above_en,
    input  logic       ref_below_fault,
    input  logic       ls_cmd,
    input  logic       hs_cmd,
    output logic       hv_src_en,
    output logic       ref_en,
    output logic       ref_hi_cur,
    output logic       ref_clamp_en,
    output logic       reg_en,
    output logic       ocp_en,
    output logic       drv_en,
    output logic [1:0] mode
);
    localparam int DWELL_CYC = CLK_MHZ * DWELL_US;
    localparam int IDLE_CYC  = CLK_MHZ * IDLE_US;
    localparam int DW        = $clog2(DWELL_CYC + 1);
    localparam int IW        = $clog2(IDLE_CYC + 1);
    localparam int NIN       = 8;
    // bit positions inside the synchronized flag vector
    localparam int B_LS     = 0;
    localparam int B_HS     = 1;
    localparam int B_ON     = 2;
    localparam int B_SAVE   = 3;
    localparam int B_OFF    = 4;
    localparam int B_REFOFF = 5;
    localparam int B_REFOK  = 6;
    localparam int B_REFBAD = 7;

    typedef struct packed {
        bms_mode_e     mode;
        logic          hv;
        logic [DW-1:0] dwell;
        logic [IW-1:0] idle;
    } seq_t;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] syn;
    logic [1:0]     cmd_prev;

    assign raw_in = {ref_below_fault, ref_above_en, vcc_below_refoff, vcc_below_off,
                     vcc_below_save, vcc_above_on, hs_cmd, ls_cmd};

    bms_sync #(.W(NIN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    bms_hist #(.W(2)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (syn[B_HS:B_LS]),
        .q     (cmd_prev)
    );

    logic s_on, s_below_save, s_below_off, s_refoff, s_ref_ok, s_ref_bad;
    logic ls_edge, hs_fall;

    assign s_on         = syn[B_ON];
    assign s_below_save = syn[B_SAVE];
    assign s_below_off  = syn[B_OFF];
    assign s_refoff     = syn[B_REFOFF];
    assign s_ref_ok     = syn[B_REFOK];
    assign s_ref_bad    = syn[B_REFBAD];
    assign ls_edge      = syn[B_LS] ^ cmd_prev[0];
    assign hs_fall      = cmd_prev[1] & ~syn[B_HS];

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.mode)
            ST_STARTUP: begin
                if (s_on && !s_refoff) nxt_d.mode = ST_SAVE;
            end
            ST_SAVE: begin
                if (s_refoff)
                    nxt_d.mode = ST_STARTUP;
                else if (cur_q.dwell == DW'(DWELL_CYC) && s_ref_ok && hs_fall)
                    nxt_d.mode = ST_RUN;
            end
            ST_RUN: begin
                if (s_below_off || s_ref_bad)
                    nxt_d.mode = ST_SHDN;
                else if (!ls_edge && cur_q.idle == IW'(IDLE_CYC - 1))
                    nxt_d.mode = ST_SAVE;
            end
            ST_SHDN: begin
                if (s_refoff)  nxt_d.mode = ST_STARTUP;
                else if (s_on) nxt_d.mode = ST_SAVE;
            end
            default: nxt_d.mode = ST_STARTUP;
        endcase

        // dwell count: cycles spent in save, saturating at the required dwell
        if (cur_q.mode == ST_SAVE && nxt_d.mode == ST_SAVE)
            nxt_d.dwell = (cur_q.dwell == DW'(DWELL_CYC)) ? cur_q.dwell : cur_q.dwell + 1'b1;
        else
            nxt_d.dwell = '0;

        // inactivity count on the low-side command while running
        if (cur_q.mode == ST_RUN && nxt_d.mode == ST_RUN)
            nxt_d.idle = ls_edge ? '0 : cur_q.idle + 1'b1;
        else
            nxt_d.idle = '0;

        // start-up source: forced by state, hysteresis while in save
        unique case (nxt_d.mode)
            ST_STARTUP, ST_SHDN: nxt_d.hv = 1'b1;
            ST_RUN:              nxt_d.hv = 1'b0;
            default: begin
                if (s_on)              nxt_d.hv = 1'b0;
                else if (s_below_save) nxt_d.hv = 1'b1;
                else                   nxt_d.hv = cur_q.hv;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode  <= ST_STARTUP;
            cur_q.hv    <= 1'b1;
            cur_q.dwell <= '0;
            cur_q.idle  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode         = cur_q.mode;
    assign hv_src_en    = cur_q.hv;
    assign ref_en       = (cur_q.mode != ST_STARTUP);
    assign ref_hi_cur   = (cur_q.mode == ST_RUN);
    assign ref_clamp_en = (cur_q.mode == ST_STARTUP);
    assign reg_en       = (cur_q.mode == ST_RUN);
    assign ocp_en       = (cur_q.mode == ST_RUN);
    assign drv_en       = (cur_q.mode == ST_RUN);
endmodule

// File: rtl/bms_checker.sv
`timescale 1ns/1ps
module bms_checker
    import bms_pkg::*;
#(
    parameter int DWELL_CYC = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       hv_src_en,
    input logic       ref_en,
    input logic       ref_hi_cur,
    input logic       ref_clamp_en,
    input logic       reg_en,
    input logic       ocp_en,
    input logic       drv_en,
    input logic       refoff_s,
    input logic       ref_ok_s,
    input logic       hs_fall_s,
    input logic       ls_edge_s
);
    localparam int CW = $clog2(DWELL_CYC + 2);
    logic [CW-1:0] save_cnt_q;

    // independent count of cycles spent in save
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   save_cnt_q <= '0;
        else if (mode != ST_SAVE)     save_cnt_q <= '0;
        else if (save_cnt_q != CW'(DWELL_CYC + 1)) save_cnt_q <= save_cnt_q + 1'b1;
    end

    p_startup_outs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ST_STARTUP |-> hv_src_en && ref_clamp_en && !ref_en && !drv_en && !reg_en && !ocp_en);

    p_save_outs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ST_SAVE |-> ref_en && !ref_hi_cur && !ref_clamp_en && !drv_en && !reg_en && !ocp_en);

    p_run_outs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ST_RUN |-> !hv_src_en && ref_hi_cur && reg_en && ocp_en && drv_en && !ref_clamp_en);

    p_drv_only_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> mode == ST_RUN);

    p_shdn_outs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ST_SHDN |-> hv_src_en && ref_en && !ref_hi_cur && !drv_en && !ref_clamp_en);

    p_run_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_RUN && $past(mode) != ST_RUN) |->
            ($past(mode) == ST_SAVE && $past(hs_fall_s) && $past(ref_ok_s)
             && $past(save_cnt_q) >= CW'(DWELL_CYC)));

    p_refoff_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SAVE && refoff_s) |=> mode == ST_STARTUP);

    p_shdn_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SHDN && $past(mode) != ST_SHDN) |-> $past(mode) == ST_RUN);

    p_idle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SAVE && $past(mode) == ST_RUN) |-> !$past(ls_edge_s));
endmodule

bind ballast_mode_seq bms_checker #(.DWELL_CYC(DWELL_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .hv_src_en    (hv_src_en),
    .ref_en       (ref_en),
    .ref_hi_cur   (ref_hi_cur),
    .ref_clamp_en (ref_clamp_en),
    .reg_en       (reg_en),
    .ocp_en       (ocp_en),
    .drv_en       (drv_en),
    .refoff_s     (s_refoff),
    .ref_ok_s     (s_ref_ok),
    .hs_fall_s    (hs_fall),
    .ls_edge_s    (ls_edge)
);

// File: tb/sim_ballast_mode_seq.sv
`timescale 1ns/1ps
module sim_ballast_mode_seq;
    import bms_pkg::*;

    localparam int CLK_MHZ = 2;
    localparam int DWELL   = CLK_MHZ * 10;   // 20 cycles
    localparam int IDLE    = CLK_MHZ * 100;  // 200 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_above_on = 0, vcc_below_save = 0, vcc_below_off = 0, vcc_below_refoff = 0;
    logic ref_above_en = 0, ref_below_fault = 0, ls_cmd = 0, hs_cmd = 0;
    logic hv_src_en, ref_en, ref_hi_cur, ref_clamp_en, reg_en, ocp_en, drv_en;
    logic [1:0] mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ballast_mode_seq #(.CLK_MHZ(CLK_MHZ), .DWELL_US(10), .IDLE_US(100)) u0 (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_on(vcc_above_on), .vcc_below_save(vcc_below_save),
        .vcc_below_off(vcc_below_off), .vcc_below_refoff(vcc_below_refoff),
        .ref_above_en(ref_above_en), .ref_below_fault(ref_below_fault),
        .ls_cmd(ls_cmd), .hs_cmd(hs_cmd),
        .hv_src_en(hv_src_en), .ref_en(ref_en), .ref_hi_cur(ref_hi_cur),
        .ref_clamp_en(ref_clamp_en), .reg_en(reg_en), .ocp_en(ocp_en),
        .drv_en(drv_en), .mode(mode)
    );

    // expected {ref_en, ref_hi_cur, ref_clamp_en, reg_en, ocp_en, drv_en} per state
    function automatic logic [5:0] exp_outs(input logic [1:0] m);
        case (m)
            2'd0:    return 6'b001000;
            2'd1:    return 6'b100000;
            2'd2:    return 6'b110111;
            default: return 6'b100000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [5:0] outs();
        return {ref_en, ref_hi_cur, ref_clamp_en, reg_en, ocp_en, drv_en};
    endfunction

    task automatic enter_run();
        step(DWELL + 5);
        ref_above_en = 1; hs_cmd = 1;
        step(5);
        hs_cmd = 0;
        step(5);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R1 R2: reset state
        chk("R1 mode", mode, 2'd0);
        chk("R2 outs", outs(), exp_outs(2'd0));
        chk("R2 hv", hv_src_en, 1);

        // R3 R4: start-up to save
        vcc_above_on = 1;
        step(5);
        chk("R3 mode", mode, 2'd1);
        chk("R4 outs", outs(), exp_outs(2'd1));
        chk("R5 hv off on entry", hv_src_en, 0);

        // R5: hysteresis
        vcc_above_on = 0;
        step(6);
        chk("R5 hold low", hv_src_en, 0);
        vcc_below_save = 1;
        step(5);
        chk("R5 on below save", hv_src_en, 1);
        vcc_below_save = 0;
        step(6);
        chk("R5 hold high", hv_src_en, 1);
        vcc_above_on = 1;
        step(5);
        chk("R5 off at turn-on", hv_src_en, 0);

        // R6: healthy reference required
        step(DWELL + 5);
        ref_above_en = 0; hs_cmd = 1;
        step(5);
        hs_cmd = 0;
        step(6);
        chk("R6 no entry without reference", mode, 2'd1);

        // R7: reference-off from save
        vcc_below_refoff = 1;
        step(5);
        chk("R7 save to start-up", mode, 2'd0);
        vcc_below_refoff = 0;
        step(5);
        chk("R3 re-enter save", mode, 2'd1);

        // R6: dwell not yet elapsed
        ref_above_en = 1; hs_cmd = 1;
        step(2);
        hs_cmd = 0;
        step(6);
        chk("R6 early edge ignored", mode, 2'd1);
        step(DWELL + 10);
        chk("R6 no edge no entry", mode, 2'd1);
        hs_cmd = 1;
        step(6);
        chk("R6 rising edge ignored", mode, 2'd1);
        hs_cmd = 0;
        step(5);
        chk("R6 entry on falling edge", mode, 2'd2);
        chk("R8 outs", outs(), exp_outs(2'd2));
        chk("R8 hv", hv_src_en, 0);

        // R9: activity keeps running, silence drops to save
        for (int i = 0; i < 20; i++) begin
            ls_cmd = ~ls_cmd;
            step(IDLE / 4);
        end
        chk("R9 stays while switching", mode, 2'd2);
        ls_cmd = ~ls_cmd;
        step(IDLE - 50);
        chk("R9 before timeout", mode, 2'd2);
        step(60);
        chk("R9 timeout to save", mode, 2'd1);

        // R10 R11: reference fault, shut-down, return
        enter_run();
        chk("R6 second entry", mode, 2'd2);
        vcc_above_on = 0;
        ref_below_fault = 1;
        step(5);
        chk("R10 fault to shut-down", mode, 2'd3);
        chk("R11 outs", outs(), exp_outs(2'd3));
        chk("R11 hv", hv_src_en, 1);
        ref_below_fault = 0;
        step(10);
        chk("R11 waits for turn-on", mode, 2'd3);
        vcc_above_on = 1;
        step(5);
        chk("R11 back to save", mode, 2'd1);

        // R10 R7: supply turn-off, then reference-off from shut-down
        enter_run();
        vcc_above_on = 0;
        vcc_below_off = 1;
        step(5);
        chk("R10 turn-off to shut-down", mode, 2'd3);
        vcc_below_refoff = 1;
        vcc_above_on = 1;
        step(5);
        chk("R7 shut-down to start-up", mode, 2'd0);
        vcc_below_off = 0; vcc_below_refoff = 0;
        step(5);
        chk("R3 save again", mode, 2'd1);

        // random phase: command activity, outputs must follow the state
        void'($urandom(32'h5eed_b11a));
        enter_run();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 29) == 0) ls_cmd = ~ls_cmd;
            if ($urandom_range(0, 39) == 0) hs_cmd = ~hs_cmd;
            step(1);
            if (i % 8 == 0) begin
                chk("R4 R8 random outs", outs(), exp_outs(mode));
                if (mode == 2'd2) chk("R8 random hv", hv_src_en, 0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule